// File: doc/BRIEF.md
# Device-ID Access Router

This block sits between a shared device access bus and the targets behind it. Every access carries a 16-bit device ID, a 28-bit device-local address, 16-bit write data, a chip enable and a write enable. The router compares the ID against a split ID space. The lowest 256 IDs belong to the surrounding framework and are passed through to a dedicated framework port. Higher IDs are decoded to the core's own targets. Read data and the stall signal from the selected target are returned to the bus. Every other target sees its strobes held low.

Three core targets are built in as simple models. The first is a byte-wide RAM, whose reads come back with a zero upper byte. The second is a word-wide RAM. The third is a small register file. The register file has a scratch register, a snapshot register that is cleared when it is read, a load port for that snapshot, and a slow register that stalls the bus for one cycle. An ID that matches nothing reads as the marker 0xEEEE and never stalls. The write enable on the bus is already qualified by the access window, so a RAM write needs only the bus write enable and a matching ID. A read side effect needs the chip enable as well as the ID.

Top module: `devbus_router`

## Requirements
- R1: An ID from 0x0000 to 0x00FF selects the framework port. fw_ce and fw_we follow dev_ce and dev_we. dev_rdata and dev_wait take fw_rdata and fw_wait. For any other ID, fw_ce and fw_we stay low.
- R2: An ID that matches no target (neither the reserved range nor one of the three core IDs) reads 0xEEEE, holds dev_wait low and strobes no target.
- R3: A write reaches only the target that is selected in that cycle. Changing the ID while dev_we stays high moves the write to the new target on that same cycle.
- R4: The byte RAM (ID 0x0100 by default) stores only dev_wdata[7:0]. Its reads return 0x00 in bits 15:8 and the stored byte in bits 7:0.
- R5: Each RAM covers 2^AW addresses (2048 for the byte RAM, 256 for the word RAM). A write whose address has any bit set at or above AW is dropped and does not wrap. Reads use the low AW address bits.
- R6: Register offset 1 (snapshot) is cleared by a read only when dev_ce is high. While dev_ce is low, holding that address leaves the value unchanged.
- R7: dev_wait is low except in two cases. It follows fw_wait for the framework range. It is high for exactly the first cycle of a chip-enabled read of register offset 3.
- R8: Register file (ID 0x0102) map: offset 0 is scratch (read/write). Offset 1 is the snapshot (read only). A write to offset 2 loads the snapshot, and offset 2 reads 0xEEEE. Offset 3 reads the bitwise inverse of scratch. Any other address reads 0xEEEE.
- R9: The word RAM (ID 0x0101 by default) stores and returns all 16 data bits.
- R10: After reset, scratch and snapshot read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| dev_id | input | 16 | Device ID of the access |
| dev_addr | input | 28 | Device-local address |
| dev_wdata | input | 16 | Write data |
| dev_ce | input | 1 | Access in progress |
| dev_we | input | 1 | Write access, already window-qualified |
| dev_rdata | output | 16 | Read data returned to the bus |
| dev_wait | output | 1 | Stall request returned to the bus |
| fw_ce | output | 1 | Chip enable forwarded to the framework port |
| fw_we | output | 1 | Write enable forwarded to the framework port |
| fw_rdata | input | 16 | Read data from the framework port |
| fw_wait | input | 1 | Stall request from the framework port |

## Verification
An ID change and a held write enable can fall in the same cycle. The write must then land only in the newly selected target. The bench provokes this by keeping dev_we high while it steps the ID from the byte RAM to the word RAM on consecutive cycles. It then reads both locations back to confirm that each holds only its own data. A deselected register read can also coincide with a held read-to-clear address, and the bench checks that the snapshot survives until the chip enable rises. A seeded random mix of IDs, addresses and operations is compared against bench-side models of all three targets.

// File: rtl/devbus_pkg.sv
package devbus_pkg;
   localparam logic [15:0] DEV_MARKER    = 16'hEEEE;
   localparam logic [15:0] CORE_ID_FIRST = 16'h0100;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_FW   = 3'd1,
      TGT_BYTE = 3'd2,
      TGT_WORD = 3'd3,
      TGT_REG  = 3'd4
   } tgt_e;

   localparam logic [1:0] REG_SCRATCH = 2'd0;
   localparam logic [1:0] REG_SNAP    = 2'd1;
   localparam logic [1:0] REG_LOAD    = 2'd2;
   localparam logic [1:0] REG_SLOW    = 2'd3;
endpackage

// File: rtl/devbus_id_decode.sv
module devbus_id_decode
   import devbus_pkg::*;
#(
   parameter logic [15:0] BYTE_ID = 16'h0100,
   parameter logic [15:0] WORD_ID = 16'h0101,
   parameter logic [15:0] REG_ID  = 16'h0102
) (
   input  logic [15:0] id,
   output tgt_e        tgt
);
   always_comb begin
      tgt = TGT_NONE;
      if (id < CORE_ID_FIRST)  tgt = TGT_FW;
      else if (id == BYTE_ID)  tgt = TGT_BYTE;
      else if (id == WORD_ID)  tgt = TGT_WORD;
      else if (id == REG_ID)   tgt = TGT_REG;
   end
endmodule

// File: rtl/devbus_ram.sv
module devbus_ram #(
   parameter int AW     = 11,
   parameter int DW     = 8,
   parameter int ADDR_W = 28,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > ADDR_W) begin : g_bad_aw
      $error("devbus_ram: AW out of range");
   end
   if (DW < 1 || DW > DATA_W) begin : g_bad_dw
      $error("devbus_ram: DW out of range");
   end

   logic [DW-1:0] mem [DEPTH];
   logic          in_range;

   if (AW < ADDR_W) begin : g_range_chk
      assign in_range = (addr[ADDR_W-1:AW] == '0);
   end else begin : g_range_full
      assign in_range = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we && in_range) mem[addr[AW-1:0]] <= wdata[DW-1:0];
   end

   if (DW < DATA_W) begin : g_zext
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:DW];
      assign rdata = {{(DATA_W-DW){1'b0}}, mem[addr[AW-1:0]]};
   end else begin : g_full
      assign rdata = mem[addr[AW-1:0]];
   end
endmodule

// File: rtl/devbus_regfile.sv
module devbus_regfile
   import devbus_pkg::*;
#(
   parameter int ADDR_W = 28,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              ce,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              wait_o
);
   localparam int OFF_W = 2;

   logic [DATA_W-1:0] scratch_q, snap_q;
   logic              slow_done_q;
   logic              off_ok;
   logic [OFF_W-1:0]  off;
   logic              rd_acc, wr_acc;

   assign off    = addr[OFF_W-1:0];
   assign off_ok = (addr[ADDR_W-1:OFF_W] == '0);
   assign rd_acc = sel && ce && !we && off_ok;
   assign wr_acc = sel && we && off_ok;

   always_comb begin
      rdata = DEV_MARKER;
      if (off_ok) begin
         unique case (off)
            REG_SCRATCH: rdata = scratch_q;
            REG_SNAP:    rdata = snap_q;
            REG_LOAD:    rdata = DEV_MARKER;
            REG_SLOW:    rdata = ~scratch_q;
         endcase
      end
   end

   assign wait_o = rd_acc && (off == REG_SLOW) && !slow_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q   <= '0;
         snap_q      <= '0;
         slow_done_q <= 1'b0;
      end else begin
         if (wr_acc && off == REG_SCRATCH) scratch_q <= wdata;
         if (wr_acc && off == REG_LOAD)    snap_q    <= wdata;
         else if (rd_acc && off == REG_SNAP) snap_q  <= '0;
         if (!ce)         slow_done_q <= 1'b0;
         else if (wait_o) slow_done_q <= 1'b1;
      end
   end

   p_clear_needs_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce && !we) |=> $stable(snap_q));

   p_wait_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_o && ce) |=> !wait_o);
endmodule

// File: rtl/devbus_router.sv
module devbus_router
   import devbus_pkg::*;
#(
   parameter int          ADDR_W  = 28,
   parameter int          DATA_W  = 16,
   parameter int          BYTE_AW = 11,
   parameter int          WORD_AW = 8,
   parameter logic [15:0] BYTE_ID = 16'h0100,
   parameter logic [15:0] WORD_ID = 16'h0101,
   parameter logic [15:0] REG_ID  = 16'h0102
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       dev_id,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [DATA_W-1:0] dev_wdata,
   input  logic              dev_ce,
   input  logic              dev_we,
   output logic [DATA_W-1:0] dev_rdata,
   output logic              dev_wait,
   output logic              fw_ce,
   output logic              fw_we,
   input  logic [DATA_W-1:0] fw_rdata,
   input  logic              fw_wait
);
   localparam int BYTE_DW = 8;

   if (BYTE_ID < CORE_ID_FIRST || WORD_ID < CORE_ID_FIRST || REG_ID < CORE_ID_FIRST) begin : g_bad_id
      $error("devbus_router: core IDs must lie above the reserved range");
   end
   if (BYTE_ID == WORD_ID || BYTE_ID == REG_ID || WORD_ID == REG_ID) begin : g_dup_id
      $error("devbus_router: core IDs must differ");
   end
   if (DATA_W != 16) begin : g_bad_dw
      $error("devbus_router: bus data width must be 16");
   end

   tgt_e              tgt;
   logic              byte_we, word_we, reg_sel;
   logic [DATA_W-1:0] byte_rd, word_rd, reg_rd;
   logic              reg_wait;

   devbus_id_decode #(.BYTE_ID(BYTE_ID), .WORD_ID(WORD_ID), .REG_ID(REG_ID)) u_dec (
      .id (dev_id),
      .tgt(tgt)
   );

   always_comb begin
      fw_ce     = 1'b0;
      fw_we     = 1'b0;
      byte_we   = 1'b0;
      word_we   = 1'b0;
      reg_sel   = 1'b0;
      dev_rdata = DEV_MARKER;
      dev_wait  = 1'b0;
      unique case (tgt)
         TGT_FW: begin
            fw_ce     = dev_ce;
            fw_we     = dev_we;
            dev_rdata = fw_rdata;
            dev_wait  = fw_wait;
         end
         TGT_BYTE: begin
            byte_we   = dev_we;
            dev_rdata = byte_rd;
         end
         TGT_WORD: begin
            word_we   = dev_we;
            dev_rdata = word_rd;
         end
         TGT_REG: begin
            reg_sel   = 1'b1;
            dev_rdata = reg_rd;
            dev_wait  = reg_wait;
         end
         default: ;
      endcase
   end

   devbus_ram #(.AW(BYTE_AW), .DW(BYTE_DW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_byte (
      .clk(clk), .we(byte_we), .addr(dev_addr), .wdata(dev_wdata), .rdata(byte_rd)
   );

   devbus_ram #(.AW(WORD_AW), .DW(DATA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_word (
      .clk(clk), .we(word_we), .addr(dev_addr), .wdata(dev_wdata), .rdata(word_rd)
   );

   devbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(reg_sel), .ce(dev_ce), .we(dev_we),
      .addr(dev_addr), .wdata(dev_wdata), .rdata(reg_rd), .wait_o(reg_wait)
   );

   p_unmapped_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == TGT_NONE) |-> (dev_rdata == DEV_MARKER && !dev_wait));

   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fw_we, byte_we, word_we, reg_sel && dev_we}));

   p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == TGT_BYTE) |-> (dev_rdata[15:8] == 8'h00));

   p_wait_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt != TGT_FW && tgt != TGT_REG) |-> !dev_wait);
endmodule

// File: tb/tb_devbus_router.sv
module tb_devbus_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dev_id = 16'hFFFF;
   logic [27:0] dev_addr = '0;
   logic [15:0] dev_wdata = '0;
   logic        dev_ce = 1'b0, dev_we = 1'b0;
   logic [15:0] dev_rdata;
   logic        dev_wait, fw_ce, fw_we;
   logic [15:0] fw_rdata = 16'h0;
   logic        fw_wait = 1'b0;

   int checks = 0, fails = 0;
   logic [7:0]  m_byte [2048];
   logic [15:0] m_word [256];
   logic [15:0] m_scr, m_snap;

   always #10 clk = ~clk;

   devbus_router dut (
      .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .dev_addr(dev_addr),
      .dev_wdata(dev_wdata), .dev_ce(dev_ce), .dev_we(dev_we),
      .dev_rdata(dev_rdata), .dev_wait(dev_wait), .fw_ce(fw_ce), .fw_we(fw_we),
      .fw_rdata(fw_rdata), .fw_wait(fw_wait)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic [15:0] id, input logic [27:0] a, input logic [15:0] d,
                      input logic w, input logic c);
      @(negedge clk);
      dev_id = id; dev_addr = a; dev_wdata = d; dev_we = w; dev_ce = c;
      #2;
   endtask

   task automatic idle();
      @(negedge clk);
      dev_we = 1'b0; dev_ce = 1'b0; dev_id = 16'hFFFF;
   endtask

   function automatic logic [15:0] exp_reg(input logic [27:0] a);
      if (a > 28'd3) return 16'hEEEE;
      case (a[1:0])
         2'd0: return m_scr;
         2'd1: return m_snap;
         2'd2: return 16'hEEEE;
         default: return ~m_scr;
      endcase
   endfunction

   function automatic logic [27:0] rnd_addr(input int aw);
      if ($urandom % 6 == 0) return 28'($urandom) | (28'd1 << aw);
      return 28'($urandom % (1 << aw));
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_scr = '0; m_snap = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10, R2, R7: state after reset
      acc(16'h0102, 28'd0, 16'h0, 1'b0, 1'b0);
      chk("R10 scratch after reset", dev_rdata, 16'h0000);
      acc(16'h0102, 28'd1, 16'h0, 1'b0, 1'b0);
      chk("R10 snapshot after reset", dev_rdata, 16'h0000);
      acc(16'h2345, 28'd7, 16'h0, 1'b0, 1'b1);
      chk("R2 unmapped marker", dev_rdata, 16'hEEEE);
      chk("R2 unmapped no wait", dev_wait, 1'b0);
      chk("R1 no fw strobe for core-range id", {fw_ce, fw_we}, 2'b00);

      // prefill both RAMs and their models
      for (int i = 0; i < 2048; i++) begin
         acc(16'h0100, 28'(i), 16'(i * 37), 1'b1, 1'b1);
         m_byte[i] = 8'(i * 37);
      end
      for (int i = 0; i < 256; i++) begin
         acc(16'h0101, 28'(i), 16'(i * 4099), 1'b1, 1'b1);
         m_word[i] = 16'(i * 4099);
      end

      // R4: byte lane only, zero-extended
      acc(16'h0100, 28'd3, 16'hABCD, 1'b1, 1'b1); m_byte[3] = 8'hCD;
      acc(16'h0100, 28'd3, 16'h0, 1'b0, 1'b1);
      chk("R4 byte zero-extend", dev_rdata, 16'h00CD);
      // R5: high-address write dropped, no wrap
      acc(16'h0100, 28'h800 | 28'd3, 16'h0055, 1'b1, 1'b1);
      acc(16'h0100, 28'd3, 16'h0, 1'b0, 1'b1);
      chk("R5 out-of-range byte write dropped", dev_rdata, 16'h00CD);
      acc(16'h0101, 28'h100 | 28'd9, 16'h7777, 1'b1, 1'b1);
      acc(16'h0101, 28'd9, 16'h0, 1'b0, 1'b1);
      chk("R5 out-of-range word write dropped", dev_rdata, m_word[9]);
      // R9: full 16-bit word
      acc(16'h0101, 28'd17, 16'hF00D, 1'b1, 1'b1); m_word[17] = 16'hF00D;
      acc(16'h0101, 28'd17, 16'h0, 1'b0, 1'b1);
      chk("R9 word full width", dev_rdata, 16'hF00D);

      // R3: ID switches while the write enable stays high
      acc(16'h0100, 28'd20, 16'h1111, 1'b1, 1'b1); m_byte[20] = 8'h11;
      acc(16'h0101, 28'd20, 16'h2222, 1'b1, 1'b1); m_word[20] = 16'h2222;
      acc(16'h0100, 28'd20, 16'h0, 1'b0, 1'b1);
      chk("R3 byte keeps own write", dev_rdata, 16'h0011);
      acc(16'h0101, 28'd20, 16'h0, 1'b0, 1'b1);
      chk("R3 word keeps own write", dev_rdata, 16'h2222);

      // R8, R6: snapshot load, held read without ce, clear with ce
      acc(16'h0102, 28'd0, 16'h0F0F, 1'b1, 1'b1); m_scr = 16'h0F0F;
      acc(16'h0102, 28'd2, 16'h5A5A, 1'b1, 1'b1); m_snap = 16'h5A5A;
      acc(16'h0102, 28'd2, 16'h0, 1'b0, 1'b1);
      chk("R8 load offset reads marker", dev_rdata, 16'hEEEE);
      acc(16'h0102, 28'd1, 16'h0, 1'b0, 1'b0);
      acc(16'h0102, 28'd1, 16'h0, 1'b0, 1'b0);
      acc(16'h0102, 28'd1, 16'h0, 1'b0, 1'b0);
      chk("R6 snapshot held without ce", dev_rdata, 16'h5A5A);
      acc(16'h0102, 28'd1, 16'h0, 1'b0, 1'b1);
      chk("R6 snapshot read value", dev_rdata, 16'h5A5A);
      acc(16'h0102, 28'd1, 16'h0, 1'b0, 1'b0);
      chk("R6 snapshot cleared after ce read", dev_rdata, 16'h0000);
      m_snap = '0;
      acc(16'h0102, 28'h10, 16'h0, 1'b0, 1'b1);
      chk("R8 undefined offset marker", dev_rdata, 16'hEEEE);

      // R7: slow register stalls exactly one cycle
      acc(16'h0102, 28'd3, 16'h0, 1'b0, 1'b1);
      chk("R7 slow read first cycle waits", dev_wait, 1'b1);
      @(negedge clk); #2;
      chk("R7 slow read second cycle ready", dev_wait, 1'b0);
      chk("R8 slow register value", dev_rdata, 16'hF0F0);
      idle();

      // R1: framework range passthrough
      fw_rdata = 16'hBEEF; fw_wait = 1'b1;
      acc(16'h00FF, 28'd5, 16'h1234, 1'b1, 1'b1);
      chk("R1 fw strobes", {fw_ce, fw_we}, 2'b11);
      chk("R1 fw rdata", dev_rdata, 16'hBEEF);
      chk("R1 fw wait", dev_wait, 1'b1);
      fw_wait = 1'b0;

      // random mix, R1..R9
      for (int n = 0; n < 800; n++) begin
         int          kind = int'($urandom % 5);
         logic        w    = 1'($urandom);
         logic        c    = w ? 1'b1 : 1'($urandom);
         logic [15:0] d    = 16'($urandom);
         logic [27:0] a;
         case (kind)
            0: begin
               fw_rdata = 16'($urandom); fw_wait = 1'($urandom);
               acc(16'($urandom % 256), 28'($urandom), d, w, c);
               chk("R1 rnd fw rdata", dev_rdata, fw_rdata);
               chk("R1 rnd fw wait", dev_wait, fw_wait);
               chk("R1 rnd fw strobes", {fw_ce, fw_we}, {c, w});
            end
            1: begin
               a = rnd_addr(11);
               acc(16'h0100, a, d, w, c);
               if (w) begin
                  if (a < 28'd2048) m_byte[a[10:0]] = d[7:0];
               end else chk("R4 R5 rnd byte read", dev_rdata, {8'h00, m_byte[a[10:0]]});
            end
            2: begin
               a = rnd_addr(8);
               acc(16'h0101, a, d, w, c);
               if (w) begin
                  if (a < 28'd256) m_word[a[7:0]] = d;
               end else chk("R9 R5 rnd word read", dev_rdata, m_word[a[7:0]]);
            end
            3: begin
               a = ($urandom % 4 == 0) ? 28'($urandom % 64) : 28'($urandom % 3);
               if (a == 28'd3) a = 28'd0;
               acc(16'h0102, a, d, w, c);
               if (w) begin
                  if (a == 28'd0) m_scr = d;
                  else if (a == 28'd2) m_snap = d;
               end else begin
                  chk("R8 rnd reg read", dev_rdata, exp_reg(a));
                  if (c && a == 28'd1) m_snap = '0;
               end
            end
            default: begin
               acc(16'h0103 + 16'($urandom % 16'hFEFC), 28'($urandom), d, w, c);
               chk("R2 rnd unmapped", {dev_wait, dev_rdata}, {1'b0, 16'hEEEE});
               chk("R3 rnd no fw strobe", {fw_ce, fw_we}, 2'b00);
            end
         endcase
      end
      idle();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule